// File: doc/BRIEF.md
# General-Purpose Event Bank with Interrupt Combiner

This block holds a bank of event status bytes and a matching bank of event enable bytes, reached through a single flat byte address space. The lower half of the space holds status bytes and the upper half holds enable bytes. Software clears pending status bits by writing ones to them and programs enables by writing whole bytes. Hardware event lines set bits in the first status byte.

The block also drives a level interrupt request toward the processor. The request is high while any pending-and-enabled event exists. The block looks for such events in two places: the power-management status and enable vectors, which arrive as inputs and are filtered by a parameterised mask, and the first status/enable byte pair of the bank. Every access returns a one-cycle-late response that carries the byte as it stood before the access, together with an error flag for addresses beyond the bank.

Top module: `gpe_event_bank`

## Requirements
- R1: With H = BANK_LEN/2, an address a < H selects status byte a, and an address H <= a < BANK_LEN selects enable byte a-H.
- R2: A write to a status byte clears exactly the bits that are 1 in the write data and leaves the other bits unchanged.
- R3: A write to an enable byte replaces the whole byte with the write data.
- R4: Every access gives rsp_valid=1 on the following cycle, with rsp_rdata equal to the selected byte as it was before the access. Reads change no state.
- R5: Each cycle, the bits of evt_in are ORed into status byte 0. When a clear of the same bit happens in the same cycle, the set wins. No other status byte is affected.
- R6: irq_level is combinational and is 1 exactly when (pm_sts & pm_en & PM_COMMON_MASK) is nonzero or (status byte 0 & enable byte 0) is nonzero.
- R7: Status and enable bytes at index 1 and above never affect irq_level.
- R8: An access at an address >= BANK_LEN gives rsp_err=1 and rsp_rdata=0 on the response, and changes no byte. In-range accesses give rsp_err=0.
- R9: The default PM_COMMON_MASK is 16'h0521, which selects power-management bits 0, 5, 8 and 10. Any other bit, such as bit 1, never raises irq_level.
- R10: Reset clears every status and enable byte, and clears rsp_valid, rsp_rdata and rsp_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address |
| acc_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_rdata | output | 8 | Byte value before the access, 0 on error |
| rsp_err | output | 1 | Address was beyond the bank |
| evt_in | input | 8 | Event set lines into status byte 0 |
| pm_sts | input | PM_W | Power-management status vector |
| pm_en | input | PM_W | Power-management enable vector |
| irq_level | output | 1 | Level interrupt request |

## Verification
The hardest case to reach from the ports is a status-0 clear and an event set that land on the same bit in the same clock cycle. The set must win (R5). To reach it, the bench drives evt_in during the cycle of a write-one-to-clear access, then reads the byte back. It also checks that a plain clear without an event empties the byte. The case where only higher enable bytes are set is covered separately: the bench sets every bit of enable byte 1 while status byte 0 is pending, and confirms that the interrupt stays low.

// File: rtl/gpe_bank_pkg.sv
package gpe_bank_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      SEL_STATUS = 2'd0,
      SEL_ENABLE = 2'd1,
      SEL_NONE   = 2'd2
   } bank_sel_e;

   function automatic int idx_width(input int half);
      return (half > 1) ? $clog2(half) : 1;
   endfunction

endpackage

// File: rtl/gpe_addr_decode.sv
module gpe_addr_decode
   import gpe_bank_pkg::*;
#(
   parameter int BANK_LEN = 8,
   parameter int ADDR_W   = 4,
   parameter int IDX_W    = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output bank_sel_e         sel,
   output logic [IDX_W-1:0]  idx
);

   localparam int HALF = BANK_LEN / 2;
   localparam logic [ADDR_W:0] HALF_A = (ADDR_W+1)'(HALF);
   localparam logic [ADDR_W:0] LEN_A  = (ADDR_W+1)'(BANK_LEN);

   logic [ADDR_W:0] addr_x;
   logic [ADDR_W:0] off_en;

   assign addr_x = {1'b0, addr};
   assign off_en = addr_x - HALF_A;

   always_comb begin
      sel = SEL_NONE;
      idx = '0;
      if (addr_x < HALF_A) begin
         sel = SEL_STATUS;
         idx = addr_x[IDX_W-1:0];
      end else if (addr_x < LEN_A) begin
         sel = SEL_ENABLE;
         idx = off_en[IDX_W-1:0];
      end
   end

endmodule

// File: rtl/gpe_byte_file.sv
module gpe_byte_file
   import gpe_bank_pkg::*;
#(
   parameter int HALF  = 4,
   parameter int IDX_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_sts,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [BYTE_W-1:0] evt,
   output logic [BYTE_W-1:0] rd_sts,
   output logic [BYTE_W-1:0] rd_en,
   output logic [BYTE_W-1:0] sts0,
   output logic [BYTE_W-1:0] en0
);

   logic [BYTE_W-1:0] sts_q [HALF];
   logic [BYTE_W-1:0] en_q  [HALF];

   for (genvar g = 0; g < HALF; g++) begin : g_byte
      logic hit;
      logic [BYTE_W-1:0] set_bits;
      assign hit = (idx == IDX_W'(g));
      if (g == 0) begin : g_evt
         assign set_bits = evt;
      end else begin : g_noevt
         assign set_bits = '0;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sts_q[g] <= '0;
            en_q[g]  <= '0;
         end else begin
            if (wr_sts && hit) sts_q[g] <= (sts_q[g] & ~wdata) | set_bits;
            else               sts_q[g] <= sts_q[g] | set_bits;
            if (wr_en && hit)  en_q[g]  <= wdata;
         end
      end
   end

   always_comb begin
      rd_sts = '0;
      rd_en  = '0;
      for (int i = 0; i < HALF; i++) begin
         if (idx == IDX_W'(i)) begin
            rd_sts = sts_q[i];
            rd_en  = en_q[i];
         end
      end
   end

   assign sts0 = sts_q[0];
   assign en0  = en_q[0];

endmodule

// File: rtl/gpe_irq_combine.sv
module gpe_irq_combine
   import gpe_bank_pkg::*;
#(
   parameter int            PM_W           = 16,
   parameter logic [PM_W-1:0] PM_COMMON_MASK = 16'h0521
) (
   input  logic [PM_W-1:0]   pm_sts,
   input  logic [PM_W-1:0]   pm_en,
   input  logic [BYTE_W-1:0] sts0,
   input  logic [BYTE_W-1:0] en0,
   output logic              irq
);

   logic pm_hit;
   logic gp_hit;

   assign pm_hit = |(pm_sts & pm_en & PM_COMMON_MASK);
   assign gp_hit = |(sts0 & en0);
   assign irq    = pm_hit | gp_hit;

endmodule

// File: rtl/gpe_event_bank.sv
module gpe_event_bank
   import gpe_bank_pkg::*;
#(
   parameter int              BANK_LEN       = 8,
   parameter int              ADDR_W         = 4,
   parameter int              PM_W           = 16,
   parameter logic [PM_W-1:0] PM_COMMON_MASK = 16'h0521
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [7:0]        acc_wdata,
   output logic              rsp_valid,
   output logic [7:0]        rsp_rdata,
   output logic              rsp_err,
   input  logic [7:0]        evt_in,
   input  logic [PM_W-1:0]   pm_sts,
   input  logic [PM_W-1:0]   pm_en,
   output logic              irq_level
);

   localparam int HALF  = BANK_LEN / 2;
   localparam int IDX_W = idx_width(HALF);

   if (BANK_LEN < 2 || (BANK_LEN % 2) != 0) begin : g_bad_len
      $error("BANK_LEN must be even and at least 2");
   end
   if (BANK_LEN > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for BANK_LEN");
   end
   if (PM_W < 1) begin : g_bad_pm
      $error("PM_W must be positive");
   end

   bank_sel_e         sel;
   logic [IDX_W-1:0]  idx;
   logic [7:0]        rd_sts, rd_en;
   logic [7:0]        sts0_w, en0_w;
   logic              wr_sts, wr_en;
   logic [7:0]        rd_byte;

   gpe_addr_decode #(
      .BANK_LEN(BANK_LEN), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
   ) u_dec (
      .addr(acc_addr), .sel(sel), .idx(idx)
   );

   assign wr_sts = acc_valid && acc_write && (sel == SEL_STATUS);
   assign wr_en  = acc_valid && acc_write && (sel == SEL_ENABLE);

   gpe_byte_file #(
      .HALF(HALF), .IDX_W(IDX_W)
   ) u_file (
      .clk(clk), .rst_n(rst_n),
      .wr_sts(wr_sts), .wr_en(wr_en), .idx(idx),
      .wdata(acc_wdata), .evt(evt_in),
      .rd_sts(rd_sts), .rd_en(rd_en),
      .sts0(sts0_w), .en0(en0_w)
   );

   always_comb begin
      case (sel)
         SEL_STATUS: rd_byte = rd_sts;
         SEL_ENABLE: rd_byte = rd_en;
         default:    rd_byte = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
         rsp_err   <= 1'b0;
      end else begin
         rsp_valid <= acc_valid;
         if (acc_valid) begin
            rsp_rdata <= rd_byte;
            rsp_err   <= (sel == SEL_NONE);
         end
      end
   end

   gpe_irq_combine #(
      .PM_W(PM_W), .PM_COMMON_MASK(PM_COMMON_MASK)
   ) u_irq (
      .pm_sts(pm_sts), .pm_en(pm_en),
      .sts0(sts0_w), .en0(en0_w),
      .irq(irq_level)
   );

endmodule

// File: rtl/gpe_event_bank_chk.sv
module gpe_event_bank_chk #(
   parameter int BANK_LEN = 8,
   parameter int ADDR_W   = 4,
   parameter int PM_W     = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic              acc_write,
   input logic [ADDR_W-1:0] acc_addr,
   input logic [7:0]        acc_wdata,
   input logic              rsp_valid,
   input logic [7:0]        rsp_rdata,
   input logic              rsp_err,
   input logic [7:0]        evt_in,
   input logic [PM_W-1:0]   pm_en,
   input logic              irq_level,
   input logic [7:0]        sts0,
   input logic [7:0]        en0
);

   localparam logic [ADDR_W:0] LEN_A  = (ADDR_W+1)'(BANK_LEN);
   localparam logic [ADDR_W:0] HALF_A = (ADDR_W+1)'(BANK_LEN / 2);

   logic oob;
   assign oob = ({1'b0, acc_addr} >= LEN_A);

   assert_rsp_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> rsp_valid);

   assert_err_zero_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (rsp_rdata == 8'h00));

   assert_oob_keeps_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && oob && evt_in == 8'h00)
      |=> (sts0 == $past(sts0) && en0 == $past(en0)));

   assert_event_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_in != 8'h00) |=> ((sts0 & $past(evt_in)) == $past(evt_in)));

   assert_enable_replace_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && {1'b0, acc_addr} == HALF_A)
      |=> (en0 == $past(acc_wdata)));

   assert_irq_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en0 == 8'h00 && pm_en == '0) |-> !irq_level);

endmodule

bind gpe_event_bank gpe_event_bank_chk #(
   .BANK_LEN(BANK_LEN), .ADDR_W(ADDR_W), .PM_W(PM_W)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .acc_valid(acc_valid), .acc_write(acc_write),
   .acc_addr(acc_addr), .acc_wdata(acc_wdata),
   .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
   .evt_in(evt_in), .pm_en(pm_en), .irq_level(irq_level),
   .sts0(sts0_w), .en0(en0_w)
);

// File: tb/test_gpe_event_bank.sv
module test_gpe_event_bank;

   localparam int CLK_PERIOD = 10;
   localparam int LEN  = 8;
   localparam int HALF = LEN / 2;
   localparam int AW   = 4;
   localparam int PMW  = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic acc_valid = 1'b0, acc_write = 1'b0;
   logic [AW-1:0] acc_addr = '0;
   logic [7:0] acc_wdata = '0, evt_in = '0;
   logic [PMW-1:0] pm_sts = '0, pm_en = '0;
   logic rsp_valid, rsp_err, irq_level;
   logic [7:0] rsp_rdata;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpe_event_bank #(.BANK_LEN(LEN), .ADDR_W(AW), .PM_W(PMW)) i_gpe_event_bank (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .evt_in(evt_in),
      .pm_sts(pm_sts), .pm_en(pm_en), .irq_level(irq_level));

   int n_vec = 0, n_bad = 0;
   bit done = 0;
   logic [7:0] m_sts [HALF];
   logic [7:0] m_en  [HALF];
   logic [7:0] q_d [$];
   logic       q_e [$];
   string      q_t [$];

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   // monitor: pops expected responses
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         n_vec++;
         if (q_d.size() == 0) begin
            n_bad++;
            $display("FAIL R4 unexpected response: actual %h expected none", rsp_rdata);
         end else begin
            logic [7:0] d; logic e; string t;
            d = q_d.pop_front(); e = q_e.pop_front(); t = q_t.pop_front();
            if (rsp_rdata !== d || rsp_err !== e) begin
               n_bad++;
               $display("FAIL %s data/err actual %h/%b expected %h/%b", t, rsp_rdata, rsp_err, d, e);
            end
         end
      end
   end

   task automatic model_clear();
      for (int i = 0; i < HALF; i++) begin m_sts[i] = 0; m_en[i] = 0; end
   endtask

   // driver: called at a negedge, returns at the next negedge
   task automatic access(input bit w, input int a, input logic [7:0] d,
                         input logic [7:0] ev, input string tag);
      logic [7:0] cur;
      cur = 0;
      if (a < HALF) cur = m_sts[a];
      else if (a < LEN) cur = m_en[a-HALF];
      q_d.push_back(cur); q_e.push_back(a >= LEN); q_t.push_back(tag);
      acc_valid = 1; acc_write = w; acc_addr = AW'(a); acc_wdata = d; evt_in = ev;
      if (w && a < HALF) m_sts[a] = m_sts[a] & ~d;
      else if (w && a < LEN) m_en[a-HALF] = d;
      m_sts[0] = m_sts[0] | ev;
      @(negedge clk);
      acc_valid = 0; acc_write = 0; evt_in = 0;
   endtask

   task automatic pulse(input logic [7:0] ev);
      evt_in = ev; m_sts[0] = m_sts[0] | ev;
      @(negedge clk);
      evt_in = 0;
   endtask

   task automatic check_irq(input logic exp, input string tag);
      n_vec++;
      if (irq_level !== exp) begin
         n_bad++;
         $display("FAIL %s irq_level actual %b expected %b", tag, irq_level, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 0; model_clear();
      repeat (2) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD*100000);
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      @(negedge clk);
      do_reset();
      n_vec++;
      if (rsp_valid !== 0 || rsp_rdata !== 0 || rsp_err !== 0) begin
         n_bad++; $display("FAIL R10 rsp after reset actual %b/%h/%b expected 0/00/0", rsp_valid, rsp_rdata, rsp_err);
      end
      for (int a = 0; a < LEN; a++) access(0, a, 0, 0, "R10_R1_reset_read");
      check_irq(0, "R10 irq after reset");

      pulse(8'h05);
      access(0, 0, 0, 0, "R5 event into status0");
      access(0, 1, 0, 0, "R5 status1 untouched");
      check_irq(0, "R6 no enable");
      access(1, 4, 8'h04, 0, "R3 enable0 write");
      access(0, 4, 0, 0, "R3 enable0 readback");
      check_irq(1, "R6 status0&enable0");
      access(1, 0, 8'h04, 0, "R2 w1c status0");
      access(0, 0, 0, 0, "R2 status0 after clear");
      check_irq(0, "R6 cleared");

      access(1, 5, 8'hFF, 0, "R1 enable1 write");
      access(0, 5, 0, 0, "R1 enable1 readback");
      check_irq(0, "R7 enable1 ignored");
      access(1, 1, 8'hFF, 0, "R2 w1c empty status1");
      access(0, 1, 0, 0, "R2 status1 still zero");

      access(1, 9, 8'hFF, 0, "R8 oob write");
      access(0, 15, 0, 0, "R8 oob read");
      access(0, 4, 0, 0, "R8 enable0 kept");
      access(0, 0, 0, 0, "R8 status0 kept");

      access(1, 0, 8'h01, 8'h01, "R5 clear and set same cycle");
      access(0, 0, 0, 0, "R5 set wins");
      access(1, 0, 8'h01, 0, "R2 plain clear");
      access(0, 0, 0, 0, "R2 status0 empty");
      access(1, 7, 8'h3C, 0, "R3 enable3 write");
      access(1, 7, 8'h81, 0, "R3 enable3 replace");
      access(0, 7, 0, 0, "R3 enable3 readback");

      pm_sts = 16'h0001; pm_en = 16'h0001; #1 check_irq(1, "R9 pm bit0");
      pm_sts = 16'h0020; pm_en = 16'h0020; #1 check_irq(1, "R9 pm bit5");
      pm_sts = 16'h0100; pm_en = 16'h0100; #1 check_irq(1, "R9 pm bit8");
      pm_sts = 16'h0400; pm_en = 16'h0400; #1 check_irq(1, "R9 pm bit10");
      pm_sts = 16'h0002; pm_en = 16'h0002; #1 check_irq(0, "R9 pm bit1 masked");
      pm_sts = 16'h0001; pm_en = 16'h0000; #1 check_irq(0, "R6 pm not enabled");
      pm_sts = 0; pm_en = 0;
      @(negedge clk);

      pulse(8'h80);
      do_reset();
      for (int a = 0; a < LEN; a++) access(0, a, 0, 0, "R10 reset clears bank");
      @(negedge clk);
      @(negedge clk);
      if (q_d.size() != 0) begin
         n_bad++; $display("FAIL R4 missing responses actual %0d expected 0", q_d.size());
      end
      finish_run();
   end

endmodule